// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block sits between an 8-bit external memory port and the instruction decoder. It holds a 16-bit code segment and a 16-bit fetch offset. It builds a 20-bit physical byte address from them and keeps a small byte queue filled with the instruction stream, one byte per memory read. The decoder takes bytes from the head of the queue with a valid/ready handshake. While it does so, the unit keeps reading ahead.

A taken jump presents a new segment and offset. A write to the segment alone or to the offset alone also counts as a redirect. On any redirect the queue is emptied and fetching restarts at the new location. A read that is still in flight when the redirect happens is thrown away when its data returns. At most one memory read is outstanding at any time. Reads stop while the queue is full.

Top module: `seg_prefetch_unit`

## Requirements
- R1: Every read request carries the address `(segment * 16 + offset) mod 2^20` taken from the current segment and offset. For example, segment 1234h with offset 0022h gives 12362h, and segment FFFFh with offset 0015h gives 00005h.
- R2: The offset advances by one for each byte that is written into the queue. It wraps from FFFFh to 0000h and does not change the segment.
- R3: `rd_req` is high for exactly one cycle per read. No new read is issued while a read is outstanding, which means until the cycle in which `rd_valid` is sampled for it.
- R4: The queue holds DEPTH bytes (6 by default). No read is issued while it holds DEPTH bytes.
- R5: `ibyte_valid` is high exactly when the queue is not empty. `ibyte_data` shows the oldest byte and stays stable until it is taken. A byte is removed on a cycle where `ibyte_valid` and `ibyte_ready` are both high. Bytes leave in the order their reads were issued.
- R6: A cycle with `jmp_valid` high empties the queue and loads both segment and offset from `jmp_seg` and `jmp_ptr`. Any `ibyte_ready` in that cycle is ignored. `jmp_valid` takes priority over `seg_wr` and `ptr_wr`.
- R7: Data returned for a read that was outstanding at a redirect, or that arrives in the redirect cycle itself, never enters the queue and does not advance the offset.
- R8: `seg_wr` loads only the segment and `ptr_wr` loads only the offset, each keeping the other value. Either one also empties the queue, as R6 describes.
- R9: After reset the queue is empty, no read is outstanding, and the segment and offset hold RST_SEG and RST_OFF (FFFFh and 0000h by default). The first read, to FFFF0h, is issued in the cycle after reset is released.
- R10: No read is issued in a redirect cycle. When no read is outstanding, the first read to the new target appears in the cycle right after the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr | input | 1 | Load the code segment and restart fetching |
| seg_wdata | input | 16 | New segment value |
| ptr_wr | input | 1 | Load the fetch offset and restart fetching |
| ptr_wdata | input | 16 | New offset value |
| jmp_valid | input | 1 | Taken jump: load both values and flush the queue |
| jmp_seg | input | 16 | Jump target segment |
| jmp_ptr | input | 16 | Jump target offset |
| rd_req | output | 1 | One-cycle byte read request |
| rd_addr | output | 20 | Physical byte address of the request |
| rd_valid | input | 1 | Read data is returned this cycle |
| rd_data | input | 8 | Returned byte |
| ibyte_data | output | 8 | Byte at the head of the queue |
| ibyte_valid | output | 1 | Queue is not empty |
| ibyte_ready | input | 1 | Consumer takes the head byte |

## Verification
The assertions assume the memory answers each `rd_req` exactly once, in some later cycle, and never raises `rd_valid` unprompted. The bench memory keeps to this: it latches each request and answers it after a random delay of one to three cycles, and it keeps answering even after a redirect so that the discard path is exercised. Redirects, partial loads and consumer stalls are driven at random against a behavioural queue model. Directed sequences add the full-queue stall, redirect timing, segment and offset wrap, and a discarded in-flight read.

// File: rtl/seg_pf_pkg.sv
package seg_pf_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PA_W   = 20;
  localparam int BYTE_W = 8;
  localparam int SHIFT  = PA_W - SEG_W;

  // segment shifted left with zero fill plus offset, modulo 2^PA_W
  function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ofs;
    base = {seg, {SHIFT{1'b0}}};
    ofs  = PA_W'(off);
    return base + ofs;
  endfunction
endpackage

// File: rtl/seg_pf_addr.sv
module seg_pf_addr
  import seg_pf_pkg::*;
#(
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RST_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jmp,
  input  logic [SEG_W-1:0] jmp_seg,
  input  logic [OFF_W-1:0] jmp_off,
  input  logic             seg_ld,
  input  logic [SEG_W-1:0] seg_val,
  input  logic             off_ld,
  input  logic [OFF_W-1:0] off_val,
  input  logic             advance,
  output logic [SEG_W-1:0] seg_q,
  output logic [OFF_W-1:0] off_q,
  output logic [PA_W-1:0]  fetch_pa
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (jmp) begin
      seg_q <= jmp_seg;
      off_q <= jmp_off;
    end else if (seg_ld || off_ld) begin
      if (seg_ld) seg_q <= seg_val;
      if (off_ld) off_q <= off_val;
    end else if (advance) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign fetch_pa = phys_addr(seg_q, off_q);

  // R2: the segment only changes through a load
  a_r2_seg_hold: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !seg_ld) |=> $stable(seg_q));
endmodule

// File: rtl/seg_pf_queue.sv
module seg_pf_queue #(
  parameter int DEPTH = 6,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             valid,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             do_push;
  logic             do_pop;

  assign valid   = (count != '0);
  assign do_push = push && !clr;
  assign do_pop  = pop && valid && !clr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = store[rd_ptr];

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    do_push |-> (count < CNT_W'(DEPTH)));
  a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && !pop && !clr) |=> (valid && $stable(dout)));
  a_r6_clear_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid);
endmodule

// File: rtl/seg_pf_bus.sv
module seg_pf_bus
  import seg_pf_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic            room,
  input  logic [PA_W-1:0] next_pa,
  input  logic            rsp_valid,
  output logic            req,
  output logic [PA_W-1:0] req_pa,
  output logic            accept,
  output logic            busy
);
  logic stale;
  logic issue;

  assign issue  = !busy && room && !redirect;
  assign accept = rsp_valid && busy && !stale && !redirect;

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      req_pa <= '0;
      busy   <= 1'b0;
      stale  <= 1'b0;
    end else begin
      req <= issue;
      if (issue) req_pa <= next_pa;
      if (redirect) begin
        busy  <= busy && !rsp_valid;
        stale <= busy && !rsp_valid;
      end else if (busy && rsp_valid) begin
        busy  <= 1'b0;
        stale <= 1'b0;
      end else if (issue) begin
        busy <= 1'b1;
      end
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  a_r3_req_marks_busy: assert property (@(posedge clk) disable iff (rst)
    req |-> busy);
  a_r7_stale_in_flight: assert property (@(posedge clk) disable iff (rst)
    stale |-> busy);
  a_r10_quiet_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !req);
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
  import seg_pf_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        seg_wr,
  input  logic [15:0] seg_wdata,
  input  logic        ptr_wr,
  input  logic [15:0] ptr_wdata,
  input  logic        jmp_valid,
  input  logic [15:0] jmp_seg,
  input  logic [15:0] jmp_ptr,
  output logic        rd_req,
  output logic [19:0] rd_addr,
  input  logic        rd_valid,
  input  logic [7:0]  rd_data,
  output logic [7:0]  ibyte_data,
  output logic        ibyte_valid,
  input  logic        ibyte_ready
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             redirect;
  logic             accept;
  logic             busy;
  logic [CNT_W-1:0] fill;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  fetch_pa;

  assign redirect = jmp_valid || seg_wr || ptr_wr;

  seg_pf_addr #(.RST_SEG(RST_SEG), .RST_OFF(RST_OFF)) u_addr (
    .clk(clk), .rst(rst),
    .jmp(jmp_valid), .jmp_seg(jmp_seg), .jmp_off(jmp_ptr),
    .seg_ld(seg_wr), .seg_val(seg_wdata),
    .off_ld(ptr_wr), .off_val(ptr_wdata),
    .advance(accept),
    .seg_q(seg_q), .off_q(off_q), .fetch_pa(fetch_pa)
  );

  seg_pf_bus u_bus (
    .clk(clk), .rst(rst),
    .redirect(redirect),
    .room(fill < CNT_W'(DEPTH)),
    .next_pa(fetch_pa),
    .rsp_valid(rd_valid),
    .req(rd_req), .req_pa(rd_addr),
    .accept(accept), .busy(busy)
  );

  seg_pf_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_queue (
    .clk(clk), .rst(rst),
    .clr(redirect),
    .push(accept), .din(rd_data),
    .pop(ibyte_ready),
    .dout(ibyte_data), .valid(ibyte_valid), .count(fill)
  );

  // R1: a request's address matches the state that will absorb its data
  a_r1_req_addr: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr == phys_addr(seg_q, off_q)));
  // R4: a full queue issues nothing on the next cycle
  a_r4_full_stall: assert property (@(posedge clk) disable iff (rst)
    (fill == CNT_W'(DEPTH)) |=> !rd_req);
  // R7: the offset does not move while nothing is accepted
  a_r7_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!redirect && !accept) |=> $stable(off_q));
  // R3: environment returns data only for an outstanding read
  a_r3_rsp_only_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
endmodule

// File: tb/seg_prefetch_unit_test.sv
module seg_prefetch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_wr = 0, ptr_wr = 0, jmp_valid = 0;
  logic [15:0] seg_wdata = 0, ptr_wdata = 0, jmp_seg = 0, jmp_ptr = 0;
  logic        rd_valid = 0;
  logic [7:0]  rd_data = 0;
  logic        ibyte_ready = 0;
  logic        rd_req, ibyte_valid;
  logic [19:0] rd_addr;
  logic [7:0]  ibyte_data;

  always #4 clk = ~clk;

  seg_prefetch_unit uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int       m_seg, m_off, m_addr;
  bit       m_req, m_pend, m_drop;
  byte unsigned mq[$];
  // memory responder state
  bit       mem_busy = 0;
  int       mem_cnt = 0, mem_a = 0;

  function automatic int pa(int s, int o);
    return (s * 16 + o) % 1048576;
  endfunction

  function automatic byte unsigned memval(int a);
    return byte'((a & 255) ^ ((a >> 8) & 255) ^ ((a >> 16) * 37) ^ 8'h5A);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int  cnt = mq.size();
    bit  iss;
    if (rst) begin
      m_seg = 16'hFFFF; m_off = 0; m_req = 0; m_pend = 0; m_drop = 0;
      mq.delete();
    end else if (jmp_valid || seg_wr || ptr_wr) begin
      mq.delete();
      if (jmp_valid) begin m_seg = jmp_seg; m_off = jmp_ptr; end
      else begin
        if (seg_wr) m_seg = seg_wdata;
        if (ptr_wr) m_off = ptr_wdata;
      end
      if (rd_valid) begin m_pend = 0; m_drop = 0; end
      else m_drop = m_pend;
      m_req = 0;
    end else begin
      iss = !m_pend && cnt < 6;
      if (ibyte_ready && cnt > 0) void'(mq.pop_front());
      if (rd_valid) begin
        if (m_drop) m_drop = 0;
        else begin mq.push_back(rd_data); m_off = (m_off + 1) % 65536; end
        m_pend = 0;
      end
      m_req = iss;
      if (iss) begin m_addr = pa(m_seg, m_off); m_pend = 1; end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(rd_req == m_req, "R3 R4 R10 request", rd_req, m_req);
    if (m_req) chk(rd_addr == 20'(m_addr), "R1 R2 R8 address", rd_addr, m_addr);
    chk(ibyte_valid == (mq.size() > 0), "R5 R6 valid", ibyte_valid, mq.size() > 0);
    if (mq.size() > 0) chk(ibyte_data == mq[0], "R5 R7 data", ibyte_data, mq[0]);
    rd_valid = 0;
    if (mem_busy) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        rd_valid = 1; rd_data = memval(mem_a); mem_busy = 0;
      end
    end
    if (rd_req && !rst) begin
      mem_busy = 1; mem_cnt = 1 + ($urandom % 3); mem_a = rd_addr;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int reqs;
    int a;
    rst = 1;
    repeat (3) step();
    chk(rd_req == 0, "R9 reset request", rd_req, 0);
    chk(ibyte_valid == 0, "R9 reset empty", ibyte_valid, 0);
    rst = 0;
    step();
    chk(rd_req == 1, "R9 first request", rd_req, 1);
    chk(rd_addr == 20'hFFFF0, "R9 first address", rd_addr, 20'hFFFF0);

    // R7: redirect while the first read is in flight
    jmp_valid = 1; jmp_seg = 16'h0200; jmp_ptr = 16'h0010;
    step();
    jmp_valid = 0;
    repeat (12) if (!ibyte_valid) step();
    chk(ibyte_data == memval(pa(16'h0200, 16'h0010)), "R7 stale byte dropped",
        ibyte_data, memval(pa(16'h0200, 16'h0010)));

    // R4: fill and stall
    ibyte_ready = 0;
    repeat (40) step();
    reqs = 0;
    for (int i = 0; i < 10; i++) begin step(); reqs += rd_req; end
    chk(reqs == 0, "R4 full queue stalls", reqs, 0);

    // R6 R10 R1: jump with nothing in flight
    jmp_valid = 1; jmp_seg = 16'h1234; jmp_ptr = 16'h0022;
    ibyte_ready = 1;
    step();
    jmp_valid = 0; ibyte_ready = 0;
    chk(ibyte_valid == 0, "R6 flush empties", ibyte_valid, 0);
    step();
    chk(rd_req == 1, "R10 request after redirect", rd_req, 1);
    chk(rd_addr == 20'h12362, "R1 example address", rd_addr, 20'h12362);

    // R8: offset load keeps segment
    repeat (40) step();
    ptr_wr = 1; ptr_wdata = 16'h0100;
    step();
    ptr_wr = 0;
    step();
    chk(rd_addr == 20'h12440, "R8 offset load keeps segment", rd_addr, 20'h12440);
    repeat (40) step();
    seg_wr = 1; seg_wdata = 16'h0500;
    step();
    seg_wr = 0;
    step();
    a = pa(16'h0500, 16'h0100 + 6);
    chk(rd_addr == 20'(a), "R8 segment load keeps offset", rd_addr, a);

    // R1: segment wrap
    repeat (40) step();
    jmp_valid = 1; jmp_seg = 16'hFFFF; jmp_ptr = 16'h0015;
    step();
    jmp_valid = 0;
    step();
    chk(rd_addr == 20'h00005, "R1 address wrap", rd_addr, 20'h00005);

    // R2: offset wrap within segment
    repeat (40) step();
    jmp_valid = 1; jmp_seg = 16'h0100; jmp_ptr = 16'hFFFF;
    step();
    jmp_valid = 0;
    repeat (12) if (!ibyte_valid) step();
    ibyte_ready = 1;
    step();
    ibyte_ready = 0;
    repeat (12) if (!ibyte_valid) step();
    chk(ibyte_data == memval(20'h01000), "R2 offset wraps to 0000",
        ibyte_data, memval(20'h01000));

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 64;
      ibyte_ready = ($urandom % 4) != 0;
      jmp_valid = (r == 0) || (r == 3);
      seg_wr = (r == 1) || (r == 3);
      ptr_wr = (r == 2) || (r == 3);
      jmp_seg   = 16'($urandom);
      jmp_ptr   = ($urandom % 2) ? 16'hFFFC + 16'($urandom % 4) : 16'($urandom);
      seg_wdata = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      ptr_wdata = 16'hFFFD + 16'($urandom % 3);
      step();
    end
    jmp_valid = 0; seg_wr = 0; ptr_wr = 0;
    repeat (20) step();
    summary();
  end
endmodule